// File: doc/BRIEF.md
# Decimal Digit String Converter

This block reads a stream of 8-bit character codes, one per cycle while `sym_valid` is high, and turns a run of unsigned decimal digits closed by an asterisk into a binary integer. Three states drive it: `ST_START` waits for the first digit, `ST_GATHER` folds each further digit into the running value, and `ST_HALT` is terminal. The outputs are Mealy outputs, so each strobe appears in the same cycle as the symbol that causes it.

The transitions are as follows. A digit in `ST_START` loads the value and moves to `ST_GATHER`. A digit in `ST_GATHER` multiplies the value by ten, adds the digit and stays in `ST_GATHER`. If that step would not fit, the block raises `err` and moves to `ST_HALT` instead. An asterisk in `ST_GATHER` pulses `done` with the result and moves to `ST_HALT`. Every other symbol in every state raises `err` and moves to, or stays in, `ST_HALT`.

Only the synchronous reset (`rst_n` low) leaves `ST_HALT`. While reset is held, both strobes stay low. A host applies reset before each new number.

Top module: `dec_str_conv`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to `ST_START` and clears the value. `done` and `err` stay low during reset whatever the input.
- R2: In `ST_START`, a valid digit (code 0x30 to 0x39, value = code − 0x30) loads that value and moves to `ST_GATHER` with no strobe.
- R3: In `ST_GATHER`, a valid digit d replaces the value v with 10·v + d and raises no strobe.
- R4: In `ST_GATHER`, a valid asterisk (code 0x2A) raises `done` for that cycle with `value` equal to the accumulated number, then moves to `ST_HALT`.
- R5: A valid asterisk in `ST_START` raises `err` for that cycle and moves to `ST_HALT`.
- R6: In `ST_HALT`, every valid symbol raises `err`, and the block stays in `ST_HALT` until reset.
- R7: A valid code that is neither a digit nor 0x2A (for example 0x2F, 0x3A or a letter) raises `err` and moves to `ST_HALT`.
- R8: A digit in `ST_GATHER` whose result would exceed 2^ACC_W − 1 raises `err` instead of updating the value, and moves to `ST_HALT`.
- R9: A cycle with `sym_valid` low changes neither the state nor the value and raises no strobe.
- R10: `done` and `err` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset to `ST_START`, active low |
| sym_valid | input | 1 | Qualifies `sym_code` this cycle |
| sym_code | input | SYM_W | Character code |
| done | output | 1 | Number complete; `value` holds the result this cycle |
| err | output | 1 | Symbol with no defined meaning, or an overflowing digit |
| value | output | ACC_W | Accumulated number |

## Verification
The bench builds the block with `ACC_W` reduced to 16. This puts the overflow boundary within five-digit strings, so 65535 can be checked as the largest accepted result and 65536 and 99999 as overflowing ones. The default width of 32 needs ten-digit strings to reach the same edge. The 8-bit symbol width is kept, so the code neighbours of the digit range (0x2F, 0x3A) are exercised as error inputs.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

    typedef enum logic [1:0] {
        ST_START  = 2'd0,
        ST_GATHER = 2'd1,
        ST_HALT   = 2'd2
    } dsc_state_e;

    typedef enum logic [1:0] {
        SYM_DIGIT = 2'd0,
        SYM_END   = 2'd1,
        SYM_OTHER = 2'd2
    } dsc_sym_e;

    localparam logic [7:0] CODE_ZERO = 8'h30;
    localparam logic [7:0] CODE_END  = 8'h2A;
    localparam int         RADIX     = 10;
    localparam int         DIGIT_W   = 4;

endpackage

// File: rtl/dsc_decode.sv
module dsc_decode
    import dsc_pkg::*;
#(
    parameter int SYM_W = 8
) (
    input  logic [SYM_W-1:0]   code,
    output dsc_sym_e           kind,
    output logic [DIGIT_W-1:0] digit
);

    logic [SYM_W-1:0] offset;

    always_comb begin
        offset = code - SYM_W'(CODE_ZERO);
        digit  = offset[DIGIT_W-1:0];
        if (code >= SYM_W'(CODE_ZERO) && offset < SYM_W'(RADIX))
            kind = SYM_DIGIT;
        else if (code == SYM_W'(CODE_END))
            kind = SYM_END;
        else
            kind = SYM_OTHER;
    end

endmodule

// File: rtl/dsc_accum.sv
module dsc_accum
    import dsc_pkg::*;
#(
    parameter int ACC_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               mac,
    input  logic [DIGIT_W-1:0] digit,
    output logic [ACC_W-1:0]   acc,
    output logic               ovf
);

    localparam int WIDE_W = ACC_W + 4;

    logic [WIDE_W-1:0] wide;

    always_comb begin
        wide = WIDE_W'(acc) * WIDE_W'(RADIX) + WIDE_W'(digit);
        ovf  = |wide[WIDE_W-1:ACC_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            acc <= '0;
        else if (load)
            acc <= ACC_W'(digit);
        else if (mac)
            acc <= wide[ACC_W-1:0];
    end

    assert_first_digit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> acc == ACC_W'($past(digit)));

    assert_last_digit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mac |=> (acc % ACC_W'(RADIX)) == ACC_W'($past(digit)));

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mac |-> !ovf);

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !mac) |=> $stable(acc));

endmodule

// File: rtl/dsc_ctrl.sv
module dsc_ctrl
    import dsc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sym_valid,
    input  dsc_sym_e   kind,
    input  logic       ovf,
    output logic       load,
    output logic       mac,
    output logic       done,
    output logic       err,
    output dsc_state_e state
);

    dsc_state_e nxt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_START;
        else
            state <= nxt;
    end

    always_comb begin
        nxt  = state;
        load = 1'b0;
        mac  = 1'b0;
        done = 1'b0;
        err  = 1'b0;
        if (sym_valid && rst_n) begin
            unique case (state)
                ST_START: begin
                    if (kind == SYM_DIGIT) begin
                        load = 1'b1;
                        nxt  = ST_GATHER;
                    end else begin
                        err = 1'b1;
                        nxt = ST_HALT;
                    end
                end
                ST_GATHER: begin
                    if (kind == SYM_DIGIT && !ovf) begin
                        mac = 1'b1;
                    end else if (kind == SYM_END) begin
                        done = 1'b1;
                        nxt  = ST_HALT;
                    end else begin
                        err = 1'b1;
                        nxt = ST_HALT;
                    end
                end
                ST_HALT: begin
                    err = 1'b1;
                end
                default: begin
                    err = 1'b1;
                    nxt = ST_HALT;
                end
            endcase
        end
    end

    assert_done_halts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> state == ST_HALT);

    assert_halt_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_HALT |=> state == ST_HALT);

    assert_err_halts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> state == ST_HALT);

    assert_overflow_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && state == ST_GATHER && kind == SYM_DIGIT && ovf) |-> err);

    assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_valid |=> $stable(state));

    assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

endmodule

// File: rtl/dec_str_conv.sv
module dec_str_conv
    import dsc_pkg::*;
#(
    parameter int SYM_W = 8,
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sym_valid,
    input  logic [SYM_W-1:0] sym_code,
    output logic             done,
    output logic             err,
    output logic [ACC_W-1:0] value
);

    dsc_sym_e           kind;
    logic [DIGIT_W-1:0] digit;
    logic               load;
    logic               mac;
    logic               ovf;
    dsc_state_e         state;

    dsc_decode #(.SYM_W(SYM_W)) u_decode (
        .code  (sym_code),
        .kind  (kind),
        .digit (digit)
    );

    dsc_accum #(.ACC_W(ACC_W)) u_accum (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .mac   (mac),
        .digit (digit),
        .acc   (value),
        .ovf   (ovf)
    );

    dsc_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sym_valid (sym_valid),
        .kind      (kind),
        .ovf       (ovf),
        .load      (load),
        .mac       (mac),
        .done      (done),
        .err       (err),
        .state     (state)
    );

    assert_null_in_reset_R1: assert property (@(posedge clk)
        !rst_n |-> (!done && !err));

endmodule

// File: tb/sim_dec_str_conv.sv
`timescale 1ns/1ps
module sim_dec_str_conv;

    localparam int     TB_ACC_W = 16;
    localparam longint MAXV     = (64'd1 << TB_ACC_W) - 1;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                sym_valid = 1'b0;
    logic [7:0]          sym_code = 8'h00;
    logic                done;
    logic                err;
    logic [TB_ACC_W-1:0] value;

    int n_chk  = 0;
    int n_fail = 0;

    int     m_state = 0;
    longint m_acc   = 0;

    always #2.5 clk = ~clk;

    dec_str_conv #(.SYM_W(8), .ACC_W(TB_ACC_W)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .sym_valid (sym_valid),
        .sym_code  (sym_code),
        .done      (done),
        .err       (err),
        .value     (value)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic r, input logic v, input logic [7:0] c);
        bit     e_done = 1'b0;
        bit     e_err  = 1'b0;
        int     ns     = m_state;
        longint na     = m_acc;
        string  tag    = "R9";
        bit     isdig;
        longint d;
        longint t;
        @(negedge clk);
        rst_n     = r;
        sym_valid = v;
        sym_code  = c;
        #1;
        isdig = (c >= 8'h30) && (c <= 8'h39);
        d     = longint'(c) - 48;
        if (!r) begin
            tag = "R1"; ns = 0; na = 0;
        end else if (v) begin
            case (m_state)
                0: begin
                    if (isdig) begin tag = "R2"; na = d; ns = 1; end
                    else if (c == 8'h2A) begin tag = "R5"; e_err = 1; ns = 2; end
                    else begin tag = "R7"; e_err = 1; ns = 2; end
                end
                1: begin
                    if (isdig) begin
                        t = m_acc * 10 + d;
                        if (t > MAXV) begin tag = "R8"; e_err = 1; ns = 2; end
                        else begin tag = "R3"; na = t; end
                    end else if (c == 8'h2A) begin
                        tag = "R4"; e_done = 1; ns = 2;
                    end else begin
                        tag = "R7"; e_err = 1; ns = 2;
                    end
                end
                default: begin tag = "R6"; e_err = 1; end
            endcase
        end
        chk(done == e_done, tag, "done", longint'(done), longint'(e_done));
        chk(err == e_err, tag, "err", longint'(err), longint'(e_err));
        chk(!(done && err), "R10", "done&err", longint'(done && err), 0);
        if (e_done)
            chk(longint'(value) == m_acc, tag, "value", longint'(value), m_acc);
        @(posedge clk);
        m_state = ns;
        m_acc   = na;
    endtask

    task automatic feed(input string s);
        for (int i = 0; i < s.len(); i++)
            step(1'b1, 1'b1, s[i]);
    endtask

    task automatic restart();
        step(1'b0, 1'b0, 8'h00);
        step(1'b0, 1'b1, 8'h2A);
    endtask

    initial begin
        // R1: reset state, null outputs while held with a live symbol
        restart();
        step(1'b1, 1'b0, 8'h00);
        feed("321*");                 // R2 R3 R4
        restart();
        feed("0*");
        restart();
        feed("007*");
        restart();
        feed("*5*");                  // R5 then R6
        restart();
        feed("12a*");                 // R7 then R6
        restart();
        feed("x1");                   // R7 in start
        restart();
        feed("4/");                   // R7 lower neighbour 0x2F
        restart();
        feed("4:");                   // R7 upper neighbour 0x3A
        restart();
        feed("65535*");               // R4 largest value
        restart();
        feed("65536*");               // R8 then R6
        restart();
        feed("99999");                // R8
        restart();
        step(1'b1, 1'b1, 8'h34);      // R9 gaps between digits
        step(1'b1, 1'b0, 8'h39);
        step(1'b1, 1'b0, 8'h2A);
        step(1'b1, 1'b1, 8'h32);
        step(1'b1, 1'b0, 8'h61);
        feed("*");
        restart();
        feed("98");                   // R1 reset mid-number
        restart();
        feed("1234*");
        restart();
        feed("*");                    // R5 directly after reset
        step(1'b1, 1'b0, 8'h2A);
        feed("7");                    // R6
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R1 watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule